// File: doc/BRIEF.md
# Latency-Hiding Warp Scheduler

This block decides, on every clock cycle, which resident warp of a compute unit issues an instruction. Each warp slot holds one of three stored conditions: not resident, ready, or stalled. The warp chosen in the current cycle is the executing one. Warps enter the ready set through a launch strobe. Every warp owns a fixed slice of the register file whose base is its ID times the registers per warp. Changing from one warp to another therefore needs no register save or restore: only the base on the output changes.

While the executing warp is issuing, a memory request may arrive on the request strobe together with a latency value. That warp then leaves the ready set and a private down-counter is loaded with the latency. From the next cycle on, the scheduler picks another ready warp. The choice is round-robin and starts from the warp after the one that issued last. When the counter expires, the warp is ready again. An exit strobe removes the executing warp from the resident set. If nothing is ready, the cycle is idle. A counter of idle cycles shows how well the resident warps cover memory latency.

Top module: `warp_issue_scheduler`

## Requirements
- R1: After reset no warp is resident, issueValid is 0 and idleCount is 0.
- R2: A launch of a non-resident warp makes it ready from the next cycle. A launch naming a warp that is already resident (ready or stalled) has no effect.
- R3: In each cycle the issuing warp is the first ready warp found by searching upward from the warp that issued last, wrapping from NUM_WARPS-1 to 0. The search starts at warp 0 after reset. With no stalls, the ready warps issue in rotation, one per cycle.
- R4: issueRegBase equals issueWarp × REGS_PER_WARP (256 by default) while issueValid is 1, and 0 otherwise.
- R5: A memReq in a cycle where warp w issues, with latency L ≥ 1, keeps w out of issue for the next L cycles. The warp is ready again in the cycle after those. L = 0 acts as 1.
- R6: In the cycle after a memReq, a different ready warp issues if one exists, with no idle cycle in between.
- R7: When no resident warp is ready, issueValid is 0, and issueWarp and issueRegBase are 0.
- R8: idleCount rises by one, visible in the next cycle, for every cycle with issueValid 0. It holds in cycles that issue, and wraps at 2^IDLE_W.
- R9: An exitReq in an issuing cycle makes that warp non-resident from the next cycle. It takes priority over a memReq in the same cycle. The warp may later be launched again.
- R10: memReq and exitReq have no effect in a cycle with issueValid 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Active-low synchronous reset |
| launchValid | input | 1 | Launch strobe for warp launchWarp |
| launchWarp | input | WID_W (5) | ID of the warp to launch |
| memReq | input | 1 | Executing warp makes a long-latency memory request |
| memLatency | input | LAT_W (9) | Stall length in cycles for memReq |
| exitReq | input | 1 | Executing warp finishes and leaves the resident set |
| issueValid | output | 1 | A warp issues this cycle |
| issueWarp | output | WID_W (5) | ID of the issuing warp |
| issueRegBase | output | RB_W (13) | Register-file base of the issuing warp |
| idleCount | output | IDLE_W (16) | Number of cycles with no issue |

## Verification
The hardest case to reach is the one where every resident warp is stalled at once. The exact idle cycles must line up with the first countdown to expire, often while that expiry coincides with another warp stalling or with the round-robin pointer wrapping past the top warp. The stimulus keeps only a handful of warps resident, including the top ID. It requests memory often, with short random latencies (zero included), so that full-stall windows and simultaneous expiries happen many times. Directed sequences pin down exact stall lengths, a 300-cycle stall, relaunch of a stalled warp, and an exit that collides with a memory request.

// File: rtl/warp_sched_pkg.sv
package warp_sched_pkg;

  typedef enum logic [1:0] {
    WS_FREE  = 2'd0,
    WS_READY = 2'd1,
    WS_STALL = 2'd2
  } warpState_e;

  typedef struct packed {
    logic issueTick;
    logic idleTick;
  } schedStrobe_t;

endpackage

// File: rtl/warp_sched_ctrl.sv
module warp_sched_ctrl
  import warp_sched_pkg::*;
#(
  parameter int NUM_WARPS = 32,
  parameter int LAT_W     = 9,
  localparam int WID_W    = $clog2(NUM_WARPS)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             launchValid,
  input  logic [WID_W-1:0] launchWarp,
  input  logic             memReq,
  input  logic [LAT_W-1:0] memLatency,
  input  logic             exitReq,
  input  logic [WID_W-1:0] lastWarp,
  output logic             issueValid,
  output logic [WID_W-1:0] issueWarp,
  output schedStrobe_t     strobe
);

  logic [NUM_WARPS-1:0] readyVec;
  logic [NUM_WARPS-1:0] stallVec;
  logic [LAT_W-1:0]     loadVal;
  logic                 found;
  logic [WID_W-1:0]     pickW;

  // zero latency is treated as the shortest real stall
  assign loadVal = (memLatency == '0) ? LAT_W'(1) : memLatency;

  for (genvar w = 0; w < NUM_WARPS; w++) begin : gWarp
    warpState_e       stQ;
    logic [LAT_W-1:0] cntQ;
    logic             launchHit;
    logic             issueHit;

    assign launchHit = launchValid && (launchWarp == WID_W'(w));
    assign issueHit  = found && (pickW == WID_W'(w));

    always_ff @(posedge clk) begin
      if (!rstN) begin
        stQ  <= WS_FREE;
        cntQ <= '0;
      end else begin
        case (stQ)
          WS_FREE: begin
            if (launchHit) stQ <= WS_READY;
          end
          WS_READY: begin
            if (issueHit && exitReq) begin
              stQ <= WS_FREE;
            end else if (issueHit && memReq) begin
              stQ  <= WS_STALL;
              cntQ <= loadVal;
            end
          end
          WS_STALL: begin
            if (cntQ == LAT_W'(1)) stQ <= WS_READY;
            else                   cntQ <= cntQ - LAT_W'(1);
          end
          default: stQ <= WS_FREE;
        endcase
      end
    end

    assign readyVec[w] = (stQ == WS_READY);
    assign stallVec[w] = (stQ == WS_STALL);
  end

  // round-robin search starting after the last issuing warp
  always_comb begin
    int idx;
    found = 1'b0;
    pickW = '0;
    for (int k = 1; k <= NUM_WARPS; k++) begin
      idx = (int'(lastWarp) + k) % NUM_WARPS;
      if (!found && readyVec[idx]) begin
        found = 1'b1;
        pickW = idx[WID_W-1:0];
      end
    end
  end

  assign issueValid       = found;
  assign issueWarp        = pickW;
  assign strobe.issueTick = found;
  assign strobe.idleTick  = !found;

  AST_ISSUE_IS_READY: assert property (@(posedge clk) disable iff (!rstN)
    issueValid |-> readyVec[issueWarp]); // R3

  AST_STALL_AFTER_REQ: assert property (@(posedge clk) disable iff (!rstN)
    (issueValid && memReq && !exitReq) |=> stallVec[$past(issueWarp)]); // R5

  AST_NO_BACK_TO_BACK: assert property (@(posedge clk) disable iff (!rstN)
    (issueValid && memReq && !exitReq) |=> !(issueValid && issueWarp == $past(issueWarp))); // R6

  AST_EXIT_FREES: assert property (@(posedge clk) disable iff (!rstN)
    (issueValid && exitReq) |=> !readyVec[$past(issueWarp)] && !stallVec[$past(issueWarp)]); // R9

endmodule

// File: rtl/warp_sched_dp.sv
module warp_sched_dp
  import warp_sched_pkg::*;
#(
  parameter int NUM_WARPS     = 32,
  parameter int REGS_PER_WARP = 256,
  parameter int IDLE_W        = 16,
  localparam int WID_W        = $clog2(NUM_WARPS),
  localparam int RB_W         = $clog2(NUM_WARPS * REGS_PER_WARP)
) (
  input  logic              clk,
  input  logic              rstN,
  input  schedStrobe_t      strobe,
  input  logic [WID_W-1:0]  issueWarp,
  output logic [WID_W-1:0]  lastWarp,
  output logic [RB_W-1:0]   issueRegBase,
  output logic [IDLE_W-1:0] idleCount
);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      lastWarp  <= WID_W'(NUM_WARPS - 1);
      idleCount <= '0;
    end else begin
      if (strobe.issueTick) lastWarp <= issueWarp;
      if (strobe.idleTick)  idleCount <= idleCount + IDLE_W'(1);
    end
  end

  // fixed slice per warp: switching only moves this base
  assign issueRegBase = strobe.issueTick ? (RB_W'(issueWarp) * RB_W'(REGS_PER_WARP)) : '0;

  AST_IDLE_STEP: assert property (@(posedge clk) disable iff (!rstN)
    strobe.idleTick |=> idleCount == IDLE_W'($past(idleCount) + IDLE_W'(1))); // R8

  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    strobe.issueTick |=> $stable(idleCount)); // R8

endmodule

// File: rtl/warp_issue_scheduler.sv
module warp_issue_scheduler
  import warp_sched_pkg::*;
#(
  parameter int NUM_WARPS     = 32,
  parameter int REGS_PER_WARP = 256,
  parameter int LAT_W         = 9,
  parameter int IDLE_W        = 16,
  localparam int WID_W        = $clog2(NUM_WARPS),
  localparam int RB_W         = $clog2(NUM_WARPS * REGS_PER_WARP)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              launchValid,
  input  logic [WID_W-1:0]  launchWarp,
  input  logic              memReq,
  input  logic [LAT_W-1:0]  memLatency,
  input  logic              exitReq,
  output logic              issueValid,
  output logic [WID_W-1:0]  issueWarp,
  output logic [RB_W-1:0]   issueRegBase,
  output logic [IDLE_W-1:0] idleCount
);

  schedStrobe_t     strobe;
  logic [WID_W-1:0] lastWarp;

  warp_sched_ctrl #(
    .NUM_WARPS(NUM_WARPS),
    .LAT_W(LAT_W)
  ) uCtrl (
    .clk(clk),
    .rstN(rstN),
    .launchValid(launchValid),
    .launchWarp(launchWarp),
    .memReq(memReq),
    .memLatency(memLatency),
    .exitReq(exitReq),
    .lastWarp(lastWarp),
    .issueValid(issueValid),
    .issueWarp(issueWarp),
    .strobe(strobe)
  );

  warp_sched_dp #(
    .NUM_WARPS(NUM_WARPS),
    .REGS_PER_WARP(REGS_PER_WARP),
    .IDLE_W(IDLE_W)
  ) uDp (
    .clk(clk),
    .rstN(rstN),
    .strobe(strobe),
    .issueWarp(issueWarp),
    .lastWarp(lastWarp),
    .issueRegBase(issueRegBase),
    .idleCount(idleCount)
  );

endmodule

// File: tb/tb_warp_issue_scheduler.sv
module tb_warp_issue_scheduler;

  localparam int N   = 32;
  localparam int RPW = 256;

  logic        clk = 1'b0;
  logic        rstN;
  logic        launchValid;
  logic [4:0]  launchWarp;
  logic        memReq;
  logic [8:0]  memLatency;
  logic        exitReq;
  logic        issueValid;
  logic [4:0]  issueWarp;
  logic [12:0] issueRegBase;
  logic [15:0] idleCount;

  always #5 clk = ~clk;

  warp_issue_scheduler dut (
    .clk(clk), .rstN(rstN),
    .launchValid(launchValid), .launchWarp(launchWarp),
    .memReq(memReq), .memLatency(memLatency), .exitReq(exitReq),
    .issueValid(issueValid), .issueWarp(issueWarp),
    .issueRegBase(issueRegBase), .idleCount(idleCount)
  );

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;
  int mState [N];  // 0 free, 1 ready, 2 stalled
  int mCnt [N];
  int mLast;
  int mIdle;

  task automatic check(bit ok, string tag, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s act=%0d exp=%0d", tag, act, exp);
    end
  endtask

  function automatic int pickRef();
    for (int k = 1; k <= N; k++) begin
      if (mState[(mLast + k) % N] == 1) return (mLast + k) % N;
    end
    return -1;
  endfunction

  task automatic cmpOutputs(string tag);
    int p;
    p = pickRef();
    if (p < 0) begin
      check(issueValid == 1'b0, {tag, "/R7 valid"}, int'(issueValid), 0);
      check(issueWarp == 5'd0 && issueRegBase == 13'd0, {tag, "/R7 zero"}, int'(issueRegBase), 0);
    end else begin
      check(issueValid == 1'b1, {tag, " valid"}, int'(issueValid), 1);
      check(int'(issueWarp) == p, {tag, " warp"}, int'(issueWarp), p);
      check(int'(issueRegBase) == p * RPW, "R4 base", int'(issueRegBase), p * RPW);
    end
    check(int'(idleCount) == (mIdle & 16'hFFFF), "R8 idle", int'(idleCount), mIdle & 16'hFFFF);
  endtask

  task automatic step(bit lv, int lw, bit mr, int ml, bit ex, string tag);
    int p;
    cmpOutputs(tag);
    launchValid = lv; launchWarp = 5'(lw);
    memReq = mr; memLatency = 9'(ml); exitReq = ex;
    p = pickRef();
    for (int w = 0; w < N; w++) begin
      case (mState[w])
        0: if (lv && lw == w) mState[w] = 1;
        1: if (p == w) begin
             if (ex) mState[w] = 0;
             else if (mr) begin mState[w] = 2; mCnt[w] = (ml == 0) ? 1 : ml; end
           end
        default: if (mCnt[w] == 1) mState[w] = 1; else mCnt[w]--;
      endcase
    end
    if (p >= 0) mLast = p; else mIdle++;
    @(posedge clk);
    @(negedge clk);
    launchValid = 1'b0; memReq = 1'b0; exitReq = 1'b0;
  endtask

  task automatic idle(int n, string tag);
    for (int i = 0; i < n; i++) step(0, 0, 0, 0, 0, tag);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL R3 watchdog act=0 exp=1");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    rstN = 1'b0; launchValid = 1'b0; launchWarp = '0;
    memReq = 1'b0; memLatency = '0; exitReq = 1'b0;
    for (int w = 0; w < N; w++) begin mState[w] = 0; mCnt[w] = 0; end
    mLast = N - 1; mIdle = 0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rstN = 1'b1;
    check(issueValid == 1'b0, "R1 valid", int'(issueValid), 0);
    check(idleCount == 16'd0, "R1 idle", int'(idleCount), 0);

    // R10: requests with nothing issuing change nothing
    step(0, 0, 1, 5, 0, "R10");
    step(0, 0, 0, 0, 1, "R10");
    step(1, 5, 0, 0, 0, "R2");
    check(issueValid && issueWarp == 5'd5, "R2 launch", int'(issueWarp), 5);

    // R5: exact stall length, then L=0 acts as 1
    step(0, 0, 1, 3, 0, "R5");
    for (int i = 0; i < 3; i++) begin
      check(issueValid == 1'b0, "R5 stalled", int'(issueValid), 0);
      step(0, 0, 0, 0, 0, "R5");
    end
    check(issueValid && issueWarp == 5'd5, "R5 back", int'(issueWarp), 5);
    step(0, 0, 1, 0, 0, "R5");
    check(issueValid == 1'b0, "R5 zero lat", int'(issueValid), 0);
    step(0, 0, 0, 0, 0, "R5");
    check(issueValid == 1'b1, "R5 zero lat back", int'(issueValid), 1);

    // R2: relaunch of a stalled warp is ignored
    step(0, 0, 1, 10, 0, "R2");
    step(1, 5, 0, 0, 0, "R2");
    check(issueValid == 1'b0, "R2 ignored", int'(issueValid), 0);
    idle(10, "R2");

    // R3/R6: rotation across wrap, switch after a request
    step(1, 0, 0, 0, 0, "R3");
    step(1, 31, 0, 0, 0, "R3");
    step(1, 2, 0, 0, 0, "R3");
    idle(6, "R3");
    step(0, 0, 1, 4, 0, "R6");
    check(issueValid == 1'b1, "R6 no gap", int'(issueValid), 1);
    idle(6, "R6");

    // R9: exit beats memReq, then relaunch
    step(0, 0, 1, 7, 1, "R9");
    idle(5, "R9");
    step(1, 5, 0, 0, 0, "R9");
    step(1, 0, 0, 0, 1, "R9");
    idle(4, "R9");

    // long stall in the realistic range
    step(0, 0, 1, 300, 0, "R5");
    idle(310, "R5");

    // random mix, few resident warps to reach full-stall windows
    for (int i = 0; i < 4000; i++) begin
      int lw;
      lw = int'($urandom % 8);
      if (lw == 7) lw = 31;
      step(($urandom % 4) == 0, lw, ($urandom % 3) == 0, int'($urandom % 24),
           ($urandom % 40) == 0, "R3");
    end

    cmpOutputs("R3");
    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule